// File: doc/BRIEF.md
# Debug Breakpoint Comparator Unit

This unit sits beside a small CPU core. It watches the fetch-address stream and the data-memory access stream, and it raises a break request when an armed watch condition is met. There are four address slots. Slots 0 and 1 always compare program (fetch) addresses. Slots 2 and 3 are shared: depending on the selected mode, each acts as a program or data comparator, or the pair merges into a single value-plus-mask range comparator. Two further sources are built in: break on any non-sequential change of program flow, reported by the core through a flag, and single-step break.

A debugger programs the slots and the control word through a simple write port. Once any source fires, the break request latches, and a per-source status word records which sources fired. When the core resumes, it pulses `resume_i`. This pulse clears the request and the status, and it re-arms the single-step counter.

Top module: `bkpt_unit`

## Requirements
- R1: After reset `brk_o` is 0, `brk_src_o` is 0, all four slot values are 0, and the control word is 0, so every source is disabled.
- R2: Config writes go to address 0..3 (the value of slot 0..3) or address 4 (the control word). In the control word, bits [2:0] give the mode, bits [6:3] enable slots 0..3 (bit 3 is slot 0), bit 7 enables flow-change break and bit 8 enables single-step break. In mode 0, and in the unused codes 5..7, all four slots compare the fetch address. A match sets status bit i for slot i.
- R3: In mode 1, slots 0..2 compare the fetch address and slot 3 compares the data address.
- R4: In mode 2, slots 0 and 1 compare the fetch address, and slots 2 and 3 compare the data address.
- R5: In mode 3, the value of slot 2 and the mask held in slot 3 form one program range. A fetch matches when ((addr XOR value) AND mask) == 0, and the match is reported on status bit 2. Status bit 3 is never set in this mode, and the range is enabled by the enable bit of slot 2.
- R6: In mode 4, the same masked range as in R5 applies to data addresses, again reported on status bit 2.
- R7: A disabled slot never matches. Program comparisons count only in cycles with `fetch_valid_i` high, and data comparisons count only in cycles with `data_valid_i` high.
- R8: When flow-change break is enabled, a fetch-valid cycle with `flow_chg_i` high sets status bit 4.
- R9: When single-step break is enabled, the second fetch-valid cycle after a `resume_i` pulse sets status bit 5. The first such cycle, which executes the single instruction, does not set it. A fetch in the resume cycle itself is not counted.
- R10: `brk_o` and the status bits are registered and sticky: each rises the cycle after its cause. A `resume_i` cycle clears both, and any hit in that same cycle is discarded.
- R11: A config write changes behaviour from the next cycle on. A fetch in the same cycle as the write is compared against the old settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_valid_i | input | 1 | Fetch address is valid this cycle |
| fetch_addr_i | input | AW | Current fetch (program) address |
| flow_chg_i | input | 1 | Current fetch is not sequential |
| data_valid_i | input | 1 | Data access is valid this cycle |
| data_addr_i | input | AW | Data access address |
| resume_i | input | 1 | Core resumes: clear break, arm step |
| cfg_we_i | input | 1 | Config write strobe |
| cfg_addr_i | input | 3 | Config register select |
| cfg_wdata_i | input | AW | Config write data |
| brk_o | output | 1 | Sticky break request |
| brk_src_o | output | 6 | Sticky per-source status: slots 0..3, flow, step |

## Verification
The hardest situations to reach are the mode-dependent reinterpretations of slots 2 and 3. The same address must hit in one mode and stay silent in another. Getting there needs a write sequence that changes the mode while the slot values stay fixed. The stimulus therefore keeps one set of slot values, steps the control word through modes 0 to 4, and presents each test address on both the fetch bus and the data bus. The cycle-level model flags any stream that answers when it should not. Single step gets its own sequence of resume, one fetch, and a second fetch, with a write landing in the same cycle as a fetch to pin down R11.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;
  localparam int NUM_SLOTS = 4;
  localparam int NUM_SRC   = 6;
  localparam int SRC_FLOW  = 4;
  localparam int SRC_STEP  = 5;
  localparam int CFG_CTRL  = 4;
  // control word fields
  localparam int CTL_MODE_LSB = 0;
  localparam int CTL_EN_LSB   = 3;
  localparam int CTL_FLOW     = 7;
  localparam int CTL_STEP     = 8;
  localparam int CTL_W        = 9;

  typedef enum logic [2:0] {
    K_OFF   = 3'd0,
    K_PROG  = 3'd1,
    K_DATA  = 3'd2,
    K_RNG_P = 3'd3,
    K_RNG_D = 3'd4
  } kind_e;
endpackage

// File: rtl/bkpt_cfg.sv
module bkpt_cfg
  import bkpt_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [2:0]           addr_i,
  input  logic [AW-1:0]        wdata_i,
  output logic [AW-1:0]        val_o [NUM_SLOTS],
  output logic [2:0]           mode_o,
  output logic [NUM_SLOTS-1:0] en_o,
  output logic                 flow_en_o,
  output logic                 step_en_o
);
  logic [CTL_W-1:0] ctrl_q;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_val
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          val_o[s] <= '0;
      else if (we_i && addr_i == 3'(s))     val_o[s] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                 ctrl_q <= '0;
    else if (we_i && addr_i == 3'(CFG_CTRL))     ctrl_q <= wdata_i[CTL_W-1:0];
  end

  assign mode_o    = ctrl_q[CTL_MODE_LSB +: 3];
  assign en_o      = ctrl_q[CTL_EN_LSB +: NUM_SLOTS];
  assign flow_en_o = ctrl_q[CTL_FLOW];
  assign step_en_o = ctrl_q[CTL_STEP];

  // R11: control only moves on a write to its own address
  p_ctrl_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && addr_i == 3'(CFG_CTRL)) |=> $stable(ctrl_q));
endmodule

// File: rtl/bkpt_cmp.sv
module bkpt_cmp
  import bkpt_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  kind_e         kind_i,
  input  logic          en_i,
  input  logic [AW-1:0] val_i,
  input  logic [AW-1:0] mask_i,
  input  logic          fetch_v_i,
  input  logic [AW-1:0] fetch_addr_i,
  input  logic          data_v_i,
  input  logic [AW-1:0] data_addr_i,
  output logic          hit_o
);
  logic raw;

  always_comb begin
    unique case (kind_i)
      K_PROG:  raw = fetch_v_i && (fetch_addr_i == val_i);
      K_DATA:  raw = data_v_i && (data_addr_i == val_i);
      K_RNG_P: raw = fetch_v_i && (((fetch_addr_i ^ val_i) & mask_i) == '0);
      K_RNG_D: raw = data_v_i && (((data_addr_i ^ val_i) & mask_i) == '0);
      default: raw = 1'b0;
    endcase
  end

  assign hit_o = en_i && raw;

  p_prog_on_fetch_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && (kind_i == K_PROG || kind_i == K_RNG_P)) |-> fetch_v_i);
  p_data_on_access_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && (kind_i == K_DATA || kind_i == K_RNG_D)) |-> data_v_i);
  p_off_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_i == K_OFF) |-> !hit_o);
endmodule

// File: rtl/bkpt_step.sv
module bkpt_step (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic resume_i,
  input  logic fetch_v_i,
  input  logic step_en_i,
  output logic hit_o
);
  logic arm_q, seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arm_q  <= 1'b0;
      seen_q <= 1'b0;
    end else if (resume_i) begin
      arm_q  <= 1'b1;
      seen_q <= 1'b0;
    end else if (fetch_v_i && arm_q) begin
      if (seen_q) arm_q <= 1'b0;
      else        seen_q <= 1'b1;
    end
  end

  assign hit_o = step_en_i && arm_q && seen_q && fetch_v_i && !resume_i;

  p_arm_from_resume_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(arm_q) |-> $past(resume_i));
  p_one_instr_first_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resume_i |=> !hit_o || !seen_q);
endmodule

// File: rtl/bkpt_unit.sv
module bkpt_unit
  import bkpt_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               fetch_valid_i,
  input  logic [AW-1:0]      fetch_addr_i,
  input  logic               flow_chg_i,
  input  logic               data_valid_i,
  input  logic [AW-1:0]      data_addr_i,
  input  logic               resume_i,
  input  logic               cfg_we_i,
  input  logic [2:0]         cfg_addr_i,
  input  logic [AW-1:0]      cfg_wdata_i,
  output logic               brk_o,
  output logic [NUM_SRC-1:0] brk_src_o
);
  logic [AW-1:0]        slot_val [NUM_SLOTS];
  logic [2:0]           mode;
  logic [NUM_SLOTS-1:0] slot_en;
  logic                 flow_en, step_en, step_hit;
  kind_e                kind [NUM_SLOTS];
  logic [NUM_SRC-1:0]   hits;

  bkpt_cfg #(.AW(AW)) i_cfg (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .addr_i(cfg_addr_i), .wdata_i(cfg_wdata_i),
    .val_o(slot_val), .mode_o(mode), .en_o(slot_en),
    .flow_en_o(flow_en), .step_en_o(step_en)
  );

  // slot roles per mode; codes 5..7 fall back to mode 0
  always_comb begin
    kind[0] = K_PROG;
    kind[1] = K_PROG;
    kind[2] = K_PROG;
    kind[3] = K_PROG;
    unique case (mode)
      3'd1: kind[3] = K_DATA;
      3'd2: begin kind[2] = K_DATA;  kind[3] = K_DATA; end
      3'd3: begin kind[2] = K_RNG_P; kind[3] = K_OFF;  end
      3'd4: begin kind[2] = K_RNG_D; kind[3] = K_OFF;  end
      default: ;
    endcase
  end

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    bkpt_cmp #(.AW(AW)) i_cmp (
      .clk_i, .rst_ni,
      .kind_i(kind[s]), .en_i(slot_en[s]),
      .val_i(slot_val[s]), .mask_i(slot_val[NUM_SLOTS-1]),
      .fetch_v_i(fetch_valid_i), .fetch_addr_i(fetch_addr_i),
      .data_v_i(data_valid_i), .data_addr_i(data_addr_i),
      .hit_o(hits[s])
    );
  end

  bkpt_step i_step (
    .clk_i, .rst_ni,
    .resume_i, .fetch_v_i(fetch_valid_i), .step_en_i(step_en),
    .hit_o(step_hit)
  );

  assign hits[SRC_FLOW] = flow_en && fetch_valid_i && flow_chg_i;
  assign hits[SRC_STEP] = step_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      brk_o     <= 1'b0;
      brk_src_o <= '0;
    end else if (resume_i) begin
      brk_o     <= 1'b0;
      brk_src_o <= '0;
    end else begin
      brk_o     <= brk_o | (|hits);
      brk_src_o <= brk_src_o | hits;
    end
  end

  p_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (brk_o && !resume_i) |=> brk_o);
  p_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resume_i |=> (!brk_o && brk_src_o == '0));
  p_src_needs_brk_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|brk_src_o) |-> brk_o);
  p_range_slot3_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == 3'd3 || mode == 3'd4) |-> !hits[3]);
endmodule

// File: tb/test_bkpt_unit.sv
module test_bkpt_unit;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          fv = 1'b0, fl = 1'b0, dv = 1'b0, res = 1'b0, we = 1'b0;
  logic [AW-1:0] pc = '0, da = '0, wd = '0;
  logic [2:0]    wa = '0;
  logic          brk;
  logic [5:0]    src;

  int checks = 0, failures = 0;

  // reference state
  logic [AW-1:0] m_val [4];
  logic [8:0]    m_ctrl;
  logic          m_brk, m_arm, m_seen;
  logic [5:0]    m_src;

  always #2 clk = ~clk;

  bkpt_unit #(.AW(AW)) i_bkpt_unit (
    .clk_i(clk), .rst_ni(rst_n),
    .fetch_valid_i(fv), .fetch_addr_i(pc), .flow_chg_i(fl),
    .data_valid_i(dv), .data_addr_i(da), .resume_i(res),
    .cfg_we_i(we), .cfg_addr_i(wa), .cfg_wdata_i(wd),
    .brk_o(brk), .brk_src_o(src)
  );

  function automatic logic [AW-1:0] ctl(int mode, logic [3:0] en, logic f, logic s);
    return AW'({s, f, en, 3'(mode)});
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [5:0] model_hits();
    logic [5:0] h = '0;
    int mode = int'(m_ctrl[2:0]);
    for (int s = 0; s < 4; s++) h[s] = fv && pc == m_val[s];
    if (mode == 1) h[3] = dv && da == m_val[3];
    if (mode == 2) begin h[2] = dv && da == m_val[2]; h[3] = dv && da == m_val[3]; end
    if (mode == 3) begin h[2] = fv && (((pc ^ m_val[2]) & m_val[3]) == 0); h[3] = 1'b0; end
    if (mode == 4) begin h[2] = dv && (((da ^ m_val[2]) & m_val[3]) == 0); h[3] = 1'b0; end
    h[3:0] = h[3:0] & m_ctrl[6:3];
    h[4] = m_ctrl[7] && fv && fl;
    h[5] = m_ctrl[8] && m_arm && m_seen && fv;
    return h;
  endfunction

  // one clock: model advances on the edge, outputs compared at the falling edge
  task automatic cyc(string tag);
    logic [5:0] h;
    @(posedge clk);
    h = model_hits();
    if (res) begin
      m_brk = 0; m_src = '0; m_arm = 1; m_seen = 0;
    end else begin
      m_src = m_src | h;
      m_brk = m_brk | (|h);
      if (fv && m_arm) begin
        if (m_seen) m_arm = 0; else m_seen = 1;
      end
    end
    if (we && wa < 4) m_val[wa] = wd;
    if (we && wa == 4) m_ctrl = wd[8:0];
    @(negedge clk);
    chk({tag, " brk"}, 32'(brk), 32'(m_brk));
    chk({tag, " src"}, 32'(src), 32'(m_src));
    fv = 0; fl = 0; dv = 0; res = 0; we = 0;
  endtask

  task automatic wr(logic [2:0] a, logic [AW-1:0] d);
    we = 1; wa = a; wd = d;
    cyc("R11");
  endtask

  task automatic fetch(logic [AW-1:0] a, string tag);
    fv = 1; pc = a;
    cyc(tag);
  endtask

  task automatic data(logic [AW-1:0] a, string tag);
    dv = 1; da = a;
    cyc(tag);
  endtask

  task automatic resume();
    res = 1;
    cyc("R10");
  endtask

  initial begin
    #100us;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int s = 0; s < 4; s++) m_val[s] = '0;
    m_ctrl = '0; m_brk = 0; m_src = '0; m_arm = 0; m_seen = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    chk("R1 brk", 32'(brk), 0);
    chk("R1 src", 32'(src), 0);
    fetch(16'h0000, "R1");          // slot values 0 but disabled
    chk("R1 idle", 32'(src), 0);

    wr(0, 16'h0100); wr(1, 16'h0200); wr(2, 16'h0300); wr(3, 16'h0400);
    // R11: write and fetch in the same cycle use old control
    we = 1; wa = 4; wd = ctl(0, 4'hF, 0, 0); fv = 1; pc = 16'h0100;
    cyc("R11");
    chk("R11 same-cycle", 32'(src), 0);
    fetch(16'h0100, "R2");
    chk("R2 slot0", 32'(src), 32'h01);
    fetch(16'h0104, "R10");
    chk("R10 sticky", 32'(src), 32'h01);
    fetch(16'h0400, "R2");
    chk("R2 slot3", 32'(src), 32'h09);
    resume();
    chk("R10 clear", 32'(brk), 0);
    data(16'h0200, "R7");           // slot1 program only
    dv = 1; da = 16'h0300; pc = 16'h0300; cyc("R7");
    chk("R7 no fetch-valid", 32'(src), 0);

    // R3: mode 1
    wr(4, ctl(1, 4'hF, 0, 0));
    fetch(16'h0400, "R3");
    chk("R3 slot3 ignores fetch", 32'(src), 0);
    data(16'h0400, "R3");
    chk("R3 slot3 data", 32'(src), 32'h08);
    fetch(16'h0300, "R3");
    chk("R3 slot2 prog", 32'(src), 32'h0C);
    resume();

    // R4: mode 2
    wr(4, ctl(2, 4'hF, 0, 0));
    fetch(16'h0300, "R4");
    data(16'h0100, "R4");
    chk("R4 no prog on 2, no data on 0", 32'(src), 0);
    data(16'h0300, "R4");
    chk("R4 slot2 data", 32'(src), 32'h04);
    resume();

    // R7: disabled slot
    wr(4, ctl(0, 4'b1101, 0, 0));
    fetch(16'h0200, "R7");
    chk("R7 disabled", 32'(src), 0);

    // R5: program range, value 0x1230 mask 0xFFF0
    wr(2, 16'h1230); wr(3, 16'hFFF0);
    wr(4, ctl(3, 4'hF, 0, 0));
    fetch(16'h1240, "R5");
    data(16'h1235, "R5");
    fetch(16'hFFF0, "R5");          // equals slot3 word, must not hit
    chk("R5 outside", 32'(src), 0);
    fetch(16'h123F, "R5");
    chk("R5 inside", 32'(src), 32'h04);
    resume();

    // R6: data range
    wr(4, ctl(4, 4'hF, 0, 0));
    fetch(16'h1238, "R6");
    chk("R6 fetch ignored", 32'(src), 0);
    data(16'h1238, "R6");
    chk("R6 data inside", 32'(src), 32'h04);
    resume();

    // R2: unused code acts as mode 0
    wr(4, ctl(6, 4'hF, 0, 0));
    fetch(16'hFFF0, "R2");
    chk("R2 code6", 32'(src), 32'h08);
    resume();

    // R8: flow change
    wr(4, ctl(0, 4'h0, 1, 0));
    fl = 1; cyc("R8");
    chk("R8 flag without fetch", 32'(src), 0);
    fv = 1; fl = 1; pc = 16'h0055; cyc("R8");
    chk("R8 flow", 32'(src), 32'h10);

    // R9: single step
    wr(4, ctl(0, 4'h0, 0, 1));
    res = 1; fv = 1; pc = 16'h0010; cyc("R9");
    fetch(16'h0012, "R9");
    chk("R9 first instr", 32'(src), 0);
    fetch(16'h0014, "R9");
    chk("R9 step", 32'(src), 32'h20);
    chk("R9 brk", 32'(brk), 1);
    fetch(16'h0016, "R9");
    resume();
    fetch(16'h0020, "R9");
    fetch(16'h0022, "R9");
    fetch(16'h0024, "R9");
    chk("R9 once per resume", 32'(src), 32'h20);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule